// File: doc/BRIEF.md
# CAN Controller Global Mode Sequencer

This block is the global control and mode-sequencing logic of a CAN controller. The CPU writes and reads one 8-bit control register through it. The block turns those commands into controller state, using status strobes from the frame engine. It reports the true enable state of the channel. That state changes only when the protocol permits it: standby waits for an in-progress transmission to finish, and wake-up waits for the bus to go idle.

The block also does the following:
- While an abort is held, it asks the mailbox store to clear its message-object enable bitmaps.
- It arms an overload request against the next received frame.
- It picks which frame event captures the time-triggered timer.
- It forces the transmit line recessive whenever the channel is in standby or in listen-only mode.

A software reset command restores everything to the reset state in one cycle. This recovers the controller from a receiver left in a bad state by a badly timed standby.

Top module: `can_gc_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the enabled-status flag is 0, the transmit output is 1 (recessive), the receive enable is 0 and no control pulse is active.
- R2: Register layout: bit7 abort, bit6 overload request, bit5 time-triggered mode, bit4 capture-select, bit3 listen, bit2 test, bit1 enable command (1 enable, 0 standby), bit0 software reset. A write with bit0 = 0 stores bits 7..1 and reads back bit0 as 0. Abort and overload request stay set until the CPU writes them 0, and the test bit appears on the test output.
- R3: While the abort bit is set, the bitmap-clear output is 1. The transmit output keeps following the engine's transmit bit, so a frame in progress finishes unchanged.
- R4: With the enable command at 1 and the flag at 0, the enabled-status flag rises on the clock edge that samples the engine's bus-idle strobe (11 recessive bits) and not before.
- R5: With the enable command at 0 and the flag at 1, the flag stays 1 while the transmit-busy input is high. It falls on the first edge that samples transmit-busy low.
- R6: While the enabled-status flag is 0, the transmit output is 1, the receive enable is 0 and the freeze output is 1.
- R7: While the listen bit is set, the transmit output is 1. The receive enable still follows the enabled-status flag.
- R8: The timer-capture output is active only when the channel is enabled and time-triggered mode is set. It follows the start-of-frame strobe when capture-select is 0 and the end-of-frame-last-bit strobe when it is 1, in the same cycle. Outside time-triggered mode both strobes are ignored.
- R9: When the overload bit is set, a rising frame-received strobe produces exactly one one-cycle overload-request pulse, one edge later, however long the strobe stays high. With the bit clear, no pulse is produced.
- R10: The overload-sent flag sets on the edge after the engine's overload-sent strobe. It clears on a CPU write with bit6 = 0.
- R11: A write with bit0 = 1 clears every register bit, the enabled-status flag and the overload-sent flag on that edge. After the edge bit0 reads 0 and the transmit output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | CPU register write strobe |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Control register read value |
| tx_busy_i | input | 1 | Engine transmitting a frame |
| bus_idle_i | input | 1 | Engine saw 11 recessive bits |
| sof_i | input | 1 | Start-of-frame strobe |
| eof_last_i | input | 1 | Last end-of-frame bit strobe |
| rx_done_i | input | 1 | Frame received strobe |
| ovl_sent_i | input | 1 | Overload frame sent strobe |
| tx_bit_i | input | 1 | Engine's transmit bit |
| tx_o | output | 1 | Gated transmit line |
| enabled_o | output | 1 | True enabled state |
| rx_en_o | output | 1 | Receiver enable |
| freeze_o | output | 1 | Channel frozen (standby) |
| bitmap_clr_o | output | 1 | Clear message-object enable bitmaps |
| ttc_mode_o | output | 1 | Time-triggered mode active |
| test_mode_o | output | 1 | Test mode bit |
| ttc_cap_o | output | 1 | Capture the time-triggered timer |
| ovl_req_o | output | 1 | Overload frame request pulse |
| ovl_sent_o | output | 1 | Overload-sent status flag |

## Verification
The bench builds the block with its default parameters: the 8-bit register and a recessive level of 1. These values make every field position and the recessive line value directly observable at the ports. Directed scenarios place the transmit-busy release, the bus-idle strobe and a held frame-received strobe at known cycles. This checks that the enable flag moves on exactly the sampling edge and that the overload request fires once per frame. Both capture-select settings are checked against both frame strobes, with time-triggered mode on and off. Software reset is issued from a fully configured, enabled state.

// File: rtl/can_gc_pkg.sv
package can_gc_pkg;
    localparam int CTRL_W = 8;
    localparam int B_SWRES  = 0;
    localparam int B_ENA    = 1;
    localparam int B_TEST   = 2;
    localparam int B_LISTEN = 3;
    localparam int B_SYNC   = 4;
    localparam int B_TTC    = 5;
    localparam int B_OVL    = 6;
    localparam int B_ABORT  = 7;

    typedef struct packed {
        logic abort;
        logic ovl;
        logic ttc;
        logic sync_eof;
        logic listen;
        logic test;
        logic ena;
        logic swres;
    } ctrl_t;
endpackage

// File: rtl/can_gc_cmd_reg.sv
module can_gc_cmd_reg
    import can_gc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl_o,
    output logic              swres_o
);
    typedef struct packed {
        logic [CTRL_W-1:0] bits;
    } cmd_st_t;

    cmd_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        swres_o = we && wdata[B_SWRES];
        if (we) begin
            if (wdata[B_SWRES]) begin
                st_d.bits = '0;
            end else begin
                st_d.bits = wdata;
                st_d.bits[B_SWRES] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = ctrl_t'(st_q.bits);
endmodule

// File: rtl/can_gc_en_seq.sv
module can_gc_en_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_ena,
    input  logic bus_idle,
    input  logic tx_busy,
    input  logic swres,
    output logic enabled_o
);
    typedef enum logic { ST_STANDBY = 1'b0, ST_ACTIVE = 1'b1 } en_state_e;

    typedef struct packed {
        en_state_e mode;
    } en_st_t;

    en_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (swres) begin
            st_d.mode = ST_STANDBY;
        end else begin
            case (st_q.mode)
                ST_STANDBY: if (cmd_ena && bus_idle)  st_d.mode = ST_ACTIVE;
                ST_ACTIVE:  if (!cmd_ena && !tx_busy) st_d.mode = ST_STANDBY;
                default:    st_d.mode = ST_STANDBY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: ST_STANDBY};
        else        st_q <= st_d;
    end

    assign enabled_o = (st_q.mode == ST_ACTIVE);
endmodule

// File: rtl/can_gc_ovl_arm.sv
module can_gc_ovl_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic ovl_bit,
    input  logic rx_done,
    input  logic sent_strobe,
    input  logic cpu_clr,
    input  logic swres,
    output logic req_o,
    output logic sent_o
);
    typedef struct packed {
        logic rx_prev;
        logic req;
        logic sent;
    } ovl_st_t;

    ovl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (swres) begin
            st_d = '0;
        end else begin
            st_d.rx_prev = rx_done;
            st_d.req     = ovl_bit && rx_done && !st_q.rx_prev;
            if (sent_strobe)  st_d.sent = 1'b1;
            else if (cpu_clr) st_d.sent = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o  = st_q.req;
    assign sent_o = st_q.sent;
endmodule

// File: rtl/can_gc_ctrl.sv
module can_gc_ctrl
    import can_gc_pkg::*;
#(
    parameter logic RECESSIVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              tx_busy_i,
    input  logic              bus_idle_i,
    input  logic              sof_i,
    input  logic              eof_last_i,
    input  logic              rx_done_i,
    input  logic              ovl_sent_i,
    input  logic              tx_bit_i,
    output logic              tx_o,
    output logic              enabled_o,
    output logic              rx_en_o,
    output logic              freeze_o,
    output logic              bitmap_clr_o,
    output logic              ttc_mode_o,
    output logic              test_mode_o,
    output logic              ttc_cap_o,
    output logic              ovl_req_o,
    output logic              ovl_sent_o
);
    ctrl_t ctrl;
    logic  swres;
    logic  enabled;
    logic  ovl_clr;

    can_gc_cmd_reg u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .ctrl_o  (ctrl),
        .swres_o (swres)
    );

    can_gc_en_seq u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_ena   (ctrl.ena),
        .bus_idle  (bus_idle_i),
        .tx_busy   (tx_busy_i),
        .swres     (swres),
        .enabled_o (enabled)
    );

    assign ovl_clr = reg_we && !reg_wdata[B_OVL];

    can_gc_ovl_arm u_ovl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovl_bit     (ctrl.ovl),
        .rx_done     (rx_done_i),
        .sent_strobe (ovl_sent_i),
        .cpu_clr     (ovl_clr),
        .swres       (swres),
        .req_o       (ovl_req_o),
        .sent_o      (ovl_sent_o)
    );

    always_comb begin
        reg_rdata    = ctrl;
        enabled_o    = enabled;
        rx_en_o      = enabled;
        freeze_o     = !enabled;
        bitmap_clr_o = ctrl.abort;
        ttc_mode_o   = ctrl.ttc;
        test_mode_o  = ctrl.test;
        tx_o         = (enabled && !ctrl.listen) ? tx_bit_i : RECESSIVE;
        ttc_cap_o    = 1'b0;
        if (enabled && ctrl.ttc)
            ttc_cap_o = ctrl.sync_eof ? eof_last_i : sof_i;
    end
endmodule

// File: rtl/can_gc_ctrl_chk.sv
module can_gc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       tx_busy_i,
    input logic       bus_idle_i,
    input logic       tx_o,
    input logic       enabled_o,
    input logic       rx_en_o,
    input logic       ovl_req_o
);
    a_r4_rise_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enabled_o) |-> ($past(bus_idle_i) && $past(reg_rdata[1])));

    a_r5_fall_after_tx: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enabled_o) |-> (!$past(tx_busy_i) || ($past(reg_we) && $past(reg_wdata[0]))));

    a_r6_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled_o |-> (tx_o && !rx_en_o));

    a_r7_listen_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3] |-> tx_o);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_req_o |=> !ovl_req_o);

    a_r11_swres_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we) && $past(reg_wdata[0])) |-> (reg_rdata == 8'h00 && !enabled_o));

    a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we) && !$past(reg_wdata[0])) |-> (reg_rdata == $past(reg_wdata)));
endmodule

bind can_gc_ctrl can_gc_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .tx_busy_i  (tx_busy_i),
    .bus_idle_i (bus_idle_i),
    .tx_o       (tx_o),
    .enabled_o  (enabled_o),
    .rx_en_o    (rx_en_o),
    .ovl_req_o  (ovl_req_o)
);

// File: tb/can_gc_ctrl_tb_top.sv
module can_gc_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic tx_busy_i = 0, bus_idle_i = 0, sof_i = 0, eof_last_i = 0;
    logic rx_done_i = 0, ovl_sent_i = 0, tx_bit_i = 0;
    logic tx_o, enabled_o, rx_en_o, freeze_o, bitmap_clr_o;
    logic ttc_mode_o, test_mode_o, ttc_cap_o, ovl_req_o, ovl_sent_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    can_gc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_busy_i(tx_busy_i), .bus_idle_i(bus_idle_i),
        .sof_i(sof_i), .eof_last_i(eof_last_i), .rx_done_i(rx_done_i),
        .ovl_sent_i(ovl_sent_i), .tx_bit_i(tx_bit_i), .tx_o(tx_o),
        .enabled_o(enabled_o), .rx_en_o(rx_en_o), .freeze_o(freeze_o),
        .bitmap_clr_o(bitmap_clr_o), .ttc_mode_o(ttc_mode_o),
        .test_mode_o(test_mode_o), .ttc_cap_o(ttc_cap_o),
        .ovl_req_o(ovl_req_o), .ovl_sent_o(ovl_sent_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic go_enabled(input logic [7:0] cfg);
        wr(cfg | 8'h02);
        bus_idle_i = 1; @(negedge clk); bus_idle_i = 0;
    endtask

    task automatic t_reset;
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 enabled", enabled_o, 0);
        chk("R1 tx", tx_o, 1);
        chk("R1 rx_en", rx_en_o, 0);
        chk("R1 pulses", {bitmap_clr_o, ttc_cap_o, ovl_req_o, ovl_sent_o}, 4'h0);
    endtask

    task automatic t_layout;
        wr(8'hC4);
        cyc(3);
        chk("R2 readback sticky", reg_rdata, 8'hC4);
        chk("R2 test out", test_mode_o, 1);
        chk("R3 bitmap clr", bitmap_clr_o, 1);
        wr(8'h31);
        chk("R11 swres readback", reg_rdata, 8'h00);
        wr(8'h30);
        chk("R2 ttc out", ttc_mode_o, 1);
        chk("R3 bitmap clr off", bitmap_clr_o, 0);
        wr(8'h00);
    endtask

    task automatic t_enable;
        wr(8'h02);
        cyc(3);
        chk("R4 no idle yet", enabled_o, 0);
        chk("R6 standby tx", tx_o, 1);
        chk("R6 freeze", freeze_o, 1);
        bus_idle_i = 1; @(negedge clk); bus_idle_i = 0;
        chk("R4 enabled after idle", enabled_o, 1);
        chk("R6 rx_en", rx_en_o, 1);
        tx_bit_i = 0; #1;
        chk("R3 tx follows engine", tx_o, 0);
    endtask

    task automatic t_abort_inflight;
        tx_busy_i = 1; tx_bit_i = 0;
        wr(8'h82);
        chk("R3 clr while tx", bitmap_clr_o, 1);
        chk("R3 frame continues", tx_o, 0);
        wr(8'h02); tx_busy_i = 0;
    endtask

    task automatic t_standby;
        tx_busy_i = 1; tx_bit_i = 0;
        wr(8'h00);
        cyc(3);
        chk("R5 held during tx", enabled_o, 1);
        tx_busy_i = 0; @(negedge clk);
        chk("R5 dropped", enabled_o, 0);
        chk("R6 tx recessive", tx_o, 1);
        chk("R6 rx off", rx_en_o, 0);
    endtask

    task automatic t_listen;
        go_enabled(8'h08);
        tx_bit_i = 0; #1;
        chk("R7 listen tx", tx_o, 1);
        chk("R7 listen rx_en", rx_en_o, 1);
        wr(8'h02); #1;
        chk("R7 listen off", tx_o, 0);
    endtask

    task automatic t_ttc;
        int hits = 0;
        wr(8'h22);
        sof_i = 1; #1; chk("R8 sof capture", ttc_cap_o, 1);
        sof_i = 0; eof_last_i = 1; #1; chk("R8 eof ignored sel0", ttc_cap_o, 0);
        eof_last_i = 0; @(negedge clk);
        wr(8'h32);
        eof_last_i = 1; #1; chk("R8 eof capture", ttc_cap_o, 1);
        eof_last_i = 0; sof_i = 1; #1; chk("R8 sof ignored sel1", ttc_cap_o, 0);
        sof_i = 0; @(negedge clk);
        wr(8'h12);
        sof_i = 1; eof_last_i = 1; #1;
        if (ttc_cap_o) hits++;
        chk("R8 no ttc no capture", hits, 0);
        sof_i = 0; eof_last_i = 0;
        wr(8'h02);
    endtask

    task automatic t_overload;
        int pulses = 0;
        wr(8'h42);
        rx_done_i = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ovl_req_o) pulses++;
        end
        rx_done_i = 0; @(negedge clk);
        if (ovl_req_o) pulses++;
        chk("R9 one pulse per frame", pulses, 1);
        rx_done_i = 1; @(negedge clk); rx_done_i = 0;
        chk("R9 next frame pulse", ovl_req_o, 1);
        chk("R2 ovl sticky", reg_rdata[6], 1);
        wr(8'h02);
        pulses = 0;
        rx_done_i = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (ovl_req_o) pulses++;
        end
        rx_done_i = 0;
        chk("R9 no request when clear", pulses, 0);
        wr(8'h42);
        ovl_sent_i = 1; @(negedge clk); ovl_sent_i = 0;
        chk("R10 sent set", ovl_sent_o, 1);
        cyc(2);
        chk("R10 sent held", ovl_sent_o, 1);
        wr(8'h02);
        chk("R10 sent cleared", ovl_sent_o, 0);
    endtask

    task automatic t_swres;
        wr(8'hFA);
        ovl_sent_i = 1; @(negedge clk); ovl_sent_i = 0;
        chk("R11 pre enabled", enabled_o, 1);
        wr(8'h01);
        chk("R11 reg cleared", reg_rdata, 8'h00);
        chk("R11 enabled cleared", enabled_o, 0);
        chk("R11 sent cleared", ovl_sent_o, 0);
        chk("R11 tx recessive", tx_o, 1);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_enable();
        t_abort_inflight();
        t_standby();
        t_listen();
        t_ttc();
        t_overload();
        t_swres();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule